// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer with Undo History

This block keeps a circular list of in-flight instructions in program order. Out-of-order execution can then look strictly sequential to anything outside the core. The decode stage claims a slot at the tail for each instruction. It hands over the destination register index and the value that register held before the instruction, which acts as a history-file undo record. The block returns the slot index. An execution unit reports write-back by presenting that slot index on the completion port. Only the oldest slot may retire, and only once it has completed. Retiring needs no register-file action, because the new value is already in place, so the slot is simply released and its destination is reported on the commit port.

When a flush or interrupt arrives, every slot not yet retired is discarded. The block then walks the discarded slots from youngest to oldest, one per cycle. For each slot that had already completed, it presents the saved register index and old value on the undo port, so that the register file can be returned to the last retired state. The block holds busy high for the whole walk. After the walk the buffer is empty and allocation resumes at the oldest slot's index.

Top module: `rob_inorder_commit`

## Requirements
- R1: Accepted allocations receive consecutive slot indices modulo DEPTH. `alloc_idx` always shows the index the next accepted allocation will get.
- R2: `alloc_ready` is low while DEPTH slots are occupied, during the flush cycle and while busy. An allocation offered while `alloc_ready` is low is not taken.
- R3: A completion for an occupied, in-progress slot marks that slot completed. Completions may arrive in any order.
- R4: `commit_valid` is high only when the buffer is not busy, no flush is present and the oldest slot has completed. At most one slot retires per cycle, strictly oldest first. `commit_dst` carries that slot's destination register.
- R5: A flush while not busy and not empty raises `busy` from the next cycle. The walk visits one slot per cycle from the youngest to the oldest, and `busy` falls after the oldest slot is visited. No slot retires in the flush cycle or during the walk.
- R6: During the walk, `undo_valid` is high exactly for the visited slots that had completed. `undo_dst` and `undo_old` carry that slot's destination register and saved previous value.
- R7: A completion is ignored if it names a free slot, or if it arrives during the flush cycle or the walk. An ignored completion leaves that slot's state unchanged.
- R8: When the walk ends, the buffer is empty and the next allocation index equals the index of the oldest discarded slot.
- R9: After reset the buffer is empty and not busy, `alloc_idx` is 0, and `commit_valid` and `undo_valid` are low.
- R10: A flush while the buffer is empty does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Decode offers a new instruction |
| alloc_dst | input | REG_AW | Destination register of the new instruction |
| alloc_old | input | DATA_W | Value of that register before the instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | IDX_W | Slot index the next accepted allocation receives |
| cmpl_valid | input | 1 | An execution unit reports write-back |
| cmpl_idx | input | IDX_W | Slot index of the reported instruction |
| commit_valid | output | 1 | The oldest slot retires this cycle |
| commit_dst | output | REG_AW | Destination register of the retiring slot |
| flush | input | 1 | Discard all unretired slots and start the undo walk |
| busy | output | 1 | Undo walk in progress |
| undo_valid | output | 1 | Undo record presented this cycle |
| undo_dst | output | REG_AW | Register to restore |
| undo_old | output | DATA_W | Value to restore |

## Verification
The bench builds the block with DEPTH=4, REG_AW=3 and DATA_W=8. With only four slots, the full condition is reached after four allocations, and both pointers wrap from index 3 to 0 within a few dozen cycles. The undo walk is also made to cross that wrap boundary, youngest to oldest. The narrow register and data fields keep each expected undo record small enough to write by hand in the vector table. Out-of-order completion and completions aimed at free or squashed slots can also be arranged in a handful of cycles.

// File: rtl/rob_pkg.sv
package rob_pkg;

   // Life of one slot: free, allocated and in flight, or written back.
   // Retirement returns a slot to free.
   typedef enum logic [1:0] {
      PH_FREE   = 2'd0,
      PH_INPROG = 2'd1,
      PH_DONE   = 2'd2
   } rob_phase_e;

   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rob_ptr_pair.sv
module rob_ptr_pair #(
   parameter int DEPTH = 8,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             rewind,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic             empty,
   output logic             full
);
   localparam int PW = IDX_W + 1;

   if (!rob_pkg::is_pow2(DEPTH)) begin : g_depth_chk
      $error("rob_ptr_pair: DEPTH must be a power of two, at least 2");
   end
   if (IDX_W != $clog2(DEPTH)) begin : g_idx_chk
      $error("rob_ptr_pair: IDX_W must equal clog2(DEPTH)");
   end

   logic [PW-1:0] head_q, tail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else if (rewind) begin
         tail_q <= head_q;
      end else begin
         if (push) tail_q <= tail_q + PW'(1);
         if (pop)  head_q <= head_q + PW'(1);
      end
   end

   assign head_idx = head_q[IDX_W-1:0];
   assign tail_idx = tail_q[IDX_W-1:0];
   assign empty    = (head_q == tail_q);
   assign full     = (head_idx == tail_idx) && (head_q[IDX_W] != tail_q[IDX_W]);

   a_r2_push_blocked_full: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   a_r4_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
   a_r1_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q - head_q) <= PW'(DEPTH));

endmodule

// File: rtl/rob_slot_store.sv
module rob_slot_store
   import rob_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int REG_AW = 5,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [REG_AW-1:0] wr_dst,
   input  logic [DATA_W-1:0] wr_old,
   input  logic              done_en,
   input  logic [IDX_W-1:0]  done_idx,
   input  logic              free_en,
   input  logic [IDX_W-1:0]  free_idx,
   input  logic              clear_all,
   input  logic [IDX_W-1:0]  ra_idx,
   output rob_phase_e        ra_phase,
   output logic [REG_AW-1:0] ra_dst,
   input  logic [IDX_W-1:0]  rb_idx,
   output rob_phase_e        rb_phase,
   output logic [REG_AW-1:0] rb_dst,
   output logic [DATA_W-1:0] rb_old
);
   if (REG_AW < 1 || DATA_W < 1) begin : g_width_chk
      $error("rob_slot_store: REG_AW and DATA_W must be at least 1");
   end

   rob_phase_e        phase_q [DEPTH];
   logic [REG_AW-1:0] dst_q   [DEPTH];
   logic [DATA_W-1:0] old_q   [DEPTH];

   logic [DEPTH-1:0] wr_hit, done_hit, free_hit;

   for (genvar s = 0; s < DEPTH; s++) begin : g_hit
      assign wr_hit[s]   = wr_en   && (wr_idx   == IDX_W'(s));
      assign free_hit[s] = free_en && (free_idx == IDX_W'(s));
      // Only an in-flight slot can take a completion; free slots drop it.
      assign done_hit[s] = done_en && (done_idx == IDX_W'(s)) && (phase_q[s] == PH_INPROG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) phase_q[i] <= PH_FREE;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (clear_all)        phase_q[i] <= PH_FREE;
            else if (wr_hit[i])   phase_q[i] <= PH_INPROG;
            else if (free_hit[i]) phase_q[i] <= PH_FREE;
            else if (done_hit[i]) phase_q[i] <= PH_DONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (wr_hit[i]) begin
            dst_q[i] <= wr_dst;
            old_q[i] <= wr_old;
         end
      end
   end

   assign ra_phase = phase_q[ra_idx];
   assign ra_dst   = dst_q[ra_idx];
   assign rb_phase = phase_q[rb_idx];
   assign rb_dst   = dst_q[rb_idx];
   assign rb_old   = old_q[rb_idx];

   // R7: a completion aimed at a free slot leaves it free
   a_r7_free_slot_stays_free: assert property (@(posedge clk) disable iff (!rst_n)
      (done_en && !wr_en && !clear_all && phase_q[done_idx] == PH_FREE)
      |=> (phase_q[$past(done_idx)] == PH_FREE));
   // R4: a retiring slot must have completed
   a_r4_free_only_done: assert property (@(posedge clk) disable iff (!rst_n)
      free_en |-> (phase_q[free_idx] == PH_DONE));
   // R1: allocation never lands on an occupied slot
   a_r1_write_into_free: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (phase_q[wr_idx] == PH_FREE));

endmodule

// File: rtl/rob_rewind_walker.sv
module rob_rewind_walker #(
   parameter int DEPTH = 8,
   parameter int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] start_idx,
   input  logic [IDX_W-1:0] stop_idx,
   output logic             active,
   output logic [IDX_W-1:0] walk_idx,
   output logic             finish
);
   if (IDX_W < 1) begin : g_idx_chk
      $error("rob_rewind_walker: IDX_W must be at least 1");
   end

   logic             active_q;
   logic [IDX_W-1:0] walk_q;

   assign finish = active_q && (walk_q == stop_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         walk_q   <= '0;
      end else if (start && !active_q) begin
         active_q <= 1'b1;
         walk_q   <= start_idx;
      end else if (active_q) begin
         if (finish) active_q <= 1'b0;
         else        walk_q   <= walk_q - IDX_W'(1);
      end
   end

   assign active   = active_q;
   assign walk_idx = walk_q;

   // R5: walk moves one slot toward the oldest each cycle
   a_r5_walk_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !finish) |=> (active_q && walk_q == $past(walk_q) - IDX_W'(1)));
   a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> !start);

endmodule

// File: rtl/rob_inorder_commit.sv
module rob_inorder_commit
   import rob_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int REG_AW = 5,
   parameter int DATA_W = 32,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [REG_AW-1:0] alloc_dst,
   input  logic [DATA_W-1:0] alloc_old,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_idx,
   input  logic              cmpl_valid,
   input  logic [IDX_W-1:0]  cmpl_idx,
   output logic              commit_valid,
   output logic [REG_AW-1:0] commit_dst,
   input  logic              flush,
   output logic              busy,
   output logic              undo_valid,
   output logic [REG_AW-1:0] undo_dst,
   output logic [DATA_W-1:0] undo_old
);
   if (!is_pow2(DEPTH)) begin : g_depth_chk
      $error("rob_inorder_commit: DEPTH must be a power of two, at least 2");
   end
   if (IDX_W != $clog2(DEPTH)) begin : g_idx_chk
      $error("rob_inorder_commit: IDX_W must equal clog2(DEPTH)");
   end

   logic [IDX_W-1:0]  head_idx, tail_idx, walk_idx, start_idx;
   logic              empty, full, walking, walk_done;
   logic              alloc_fire, cmpl_take, rewind_start;
   rob_phase_e        head_phase, walk_phase;
   logic [REG_AW-1:0] head_dst, walk_dst;
   logic [DATA_W-1:0] walk_old;

   assign alloc_ready  = !full && !walking && !flush;
   assign alloc_fire   = alloc_valid && alloc_ready;
   assign cmpl_take    = cmpl_valid && !walking && !flush;
   assign commit_valid = !walking && !flush && !empty && (head_phase == PH_DONE);
   assign rewind_start = flush && !walking && !empty;
   assign start_idx    = tail_idx - IDX_W'(1);

   rob_ptr_pair #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (alloc_fire),
      .pop      (commit_valid),
      .rewind   (walk_done),
      .head_idx (head_idx),
      .tail_idx (tail_idx),
      .empty    (empty),
      .full     (full)
   );

   rob_slot_store #(.DEPTH(DEPTH), .REG_AW(REG_AW), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (alloc_fire),
      .wr_idx    (tail_idx),
      .wr_dst    (alloc_dst),
      .wr_old    (alloc_old),
      .done_en   (cmpl_take),
      .done_idx  (cmpl_idx),
      .free_en   (commit_valid),
      .free_idx  (head_idx),
      .clear_all (walk_done),
      .ra_idx    (head_idx),
      .ra_phase  (head_phase),
      .ra_dst    (head_dst),
      .rb_idx    (walk_idx),
      .rb_phase  (walk_phase),
      .rb_dst    (walk_dst),
      .rb_old    (walk_old)
   );

   rob_rewind_walker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rewind_start),
      .start_idx (start_idx),
      .stop_idx  (head_idx),
      .active    (walking),
      .walk_idx  (walk_idx),
      .finish    (walk_done)
   );

   assign alloc_idx  = tail_idx;
   assign commit_dst = head_dst;
   assign busy       = walking;
   assign undo_valid = walking && (walk_phase == PH_DONE);
   assign undo_dst   = walk_dst;
   assign undo_old   = walk_old;

   a_r5_flush_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !busy && !empty) |=> busy);
   a_r4_quiet_commit_in_replay: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !commit_valid);
   a_r6_undo_inside_replay: assert property (@(posedge clk) disable iff (!rst_n)
      undo_valid |-> busy);
   a_r8_empty_after_replay: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> empty);
   a_r4_head_steps_once: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> (head_idx == $past(head_idx) + IDX_W'(1)));
   a_r10_empty_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && empty && !busy) |=> !busy);

endmodule

// File: tb/sim_rob_inorder_commit.sv
module sim_rob_inorder_commit;
   localparam int DEPTH = 4, RW = 3, DW = 8, IW = 2, NV = 18;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          alloc_valid = 1'b0, cmpl_valid = 1'b0, flush = 1'b0;
   logic [RW-1:0] alloc_dst = '0;
   logic [DW-1:0] alloc_old = '0;
   logic [IW-1:0] cmpl_idx = '0;
   logic          alloc_ready, commit_valid, busy, undo_valid;
   logic [IW-1:0] alloc_idx;
   logic [RW-1:0] commit_dst, undo_dst;
   logic [DW-1:0] undo_old;
   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   rob_inorder_commit #(.DEPTH(DEPTH), .REG_AW(RW), .DATA_W(DW), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_dst(alloc_dst),
      .alloc_old(alloc_old), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
      .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .commit_valid(commit_valid),
      .commit_dst(commit_dst), .flush(flush), .busy(busy), .undo_valid(undo_valid),
      .undo_dst(undo_dst), .undo_old(undo_old));

   typedef struct packed {
      logic av; logic [2:0] areg; logic [7:0] aold; logic cv; logic [1:0] cidx; logic fl;
      logic rdy; logic [1:0] idx; logic ecv; logic [2:0] ecreg; logic ebusy;
      logic euv; logic [2:0] eureg; logic [7:0] euval;
   } vec_t;

   // inputs for the cycle | outputs expected in that cycle, before its clock edge
   localparam vec_t TAB [NV] = '{
      '{1'b1,3'd1,8'h11,1'b0,2'd0,1'b0, 1'b1,2'd0,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b1,3'd2,8'h22,1'b0,2'd0,1'b0, 1'b1,2'd1,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b1,3'd3,8'h33,1'b1,2'd1,1'b0, 1'b1,2'd2,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b1,2'd0,1'b0, 1'b1,2'd3,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b0, 1'b1,2'd3,1'b1,3'd1,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b0, 1'b1,2'd3,1'b1,3'd2,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b1,2'd2,1'b0, 1'b1,2'd3,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b0, 1'b1,2'd3,1'b1,3'd3,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b0, 1'b1,2'd3,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b1,3'd4,8'h44,1'b0,2'd0,1'b0, 1'b1,2'd3,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b1,3'd5,8'h55,1'b0,2'd0,1'b0, 1'b1,2'd0,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b1,3'd6,8'h66,1'b1,2'd0,1'b0, 1'b1,2'd1,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b1,2'd1,1'b0, 1'b1,2'd2,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b1, 1'b0,2'd2,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b0, 1'b0,2'd2,1'b0,3'd0,1'b1,1'b1,3'd6,8'h66},
      '{1'b0,3'd0,8'h00,1'b1,2'd3,1'b0, 1'b0,2'd2,1'b0,3'd0,1'b1,1'b1,3'd5,8'h55},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b0, 1'b0,2'd2,1'b0,3'd0,1'b1,1'b0,3'd0,8'h00},
      '{1'b0,3'd0,8'h00,1'b0,2'd0,1'b0, 1'b1,2'd3,1'b0,3'd0,1'b0,1'b0,3'd0,8'h00}
   };

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic av, input logic [RW-1:0] ar, input logic [DW-1:0] ao,
                        input logic cv, input logic [IW-1:0] ci, input logic fl);
      alloc_valid = av; alloc_dst = ar; alloc_old = ao;
      cmpl_valid = cv; cmpl_idx = ci; flush = fl;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog R4: actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      // R9 reset state
      chk("R9", "alloc_ready", 32'(alloc_ready), 32'd1);
      chk("R9", "alloc_idx", 32'(alloc_idx), 32'd0);
      chk("R9", "commit_valid", 32'(commit_valid), 32'd0);
      chk("R9", "busy", 32'(busy), 32'd0);
      chk("R9", "undo_valid", 32'(undo_valid), 32'd0);
      @(negedge clk);

      // Vector walk: out-of-order completion (R3), in-order retire,
      // flush across the index wrap, ignored completion during the walk (R7)
      for (int i = 0; i < NV; i++) begin
         drive(TAB[i].av, TAB[i].areg, TAB[i].aold, TAB[i].cv, TAB[i].cidx, TAB[i].fl);
         #5;
         chk("R2", $sformatf("row%0d alloc_ready", i), 32'(alloc_ready), 32'(TAB[i].rdy));
         chk("R1", $sformatf("row%0d alloc_idx", i), 32'(alloc_idx), 32'(TAB[i].idx));
         chk("R4", $sformatf("row%0d commit_valid", i), 32'(commit_valid), 32'(TAB[i].ecv));
         if (TAB[i].ecv)
            chk("R4", $sformatf("row%0d commit_dst", i), 32'(commit_dst), 32'(TAB[i].ecreg));
         chk("R5", $sformatf("row%0d busy", i), 32'(busy), 32'(TAB[i].ebusy));
         chk("R6", $sformatf("row%0d undo_valid", i), 32'(undo_valid), 32'(TAB[i].euv));
         if (TAB[i].euv) begin
            chk("R6", $sformatf("row%0d undo_dst", i), 32'(undo_dst), 32'(TAB[i].eureg));
            chk("R6", $sformatf("row%0d undo_old", i), 32'(undo_old), 32'(TAB[i].euval));
         end
         tick();
      end
      // R8 checked by the last row: empty again, next index = oldest discarded (3)

      // R10: flush on an empty buffer
      drive(1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 1'b1);
      tick();
      drive(1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 1'b0);
      #5;
      chk("R10", "busy", 32'(busy), 32'd0);
      chk("R10", "alloc_ready", 32'(alloc_ready), 32'd1);
      tick();

      // R2: fill all four slots starting at index 3
      for (int k = 0; k < DEPTH; k++) begin
         drive(1'b1, RW'(k + 1), DW'(8'hA1 + k), 1'b0, 2'd0, 1'b0);
         #5;
         chk("R1", "fill alloc_idx", 32'(alloc_idx), 32'((3 + k) % DEPTH));
         tick();
      end
      drive(1'b1, 3'd7, 8'hFF, 1'b0, 2'd0, 1'b0);
      #5;
      chk("R2", "full alloc_ready", 32'(alloc_ready), 32'd0);
      tick();
      // R3: complete youngest first; nothing retires until the oldest (idx 3) is done
      for (int k = 0; k < 3; k++) begin
         drive(1'b0, 3'd0, 8'h00, 1'b1, IW'(2 - k), 1'b0);
         #5;
         chk("R3", "early commit_valid", 32'(commit_valid), 32'd0);
         tick();
      end
      drive(1'b0, 3'd0, 8'h00, 1'b1, 2'd3, 1'b0);
      #5;
      chk("R4", "head not done commit_valid", 32'(commit_valid), 32'd0);
      tick();
      drive(1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 1'b0);
      for (int k = 0; k < DEPTH; k++) begin
         #5;
         chk("R4", "burst commit_valid", 32'(commit_valid), 32'd1);
         chk("R4", "burst commit_dst", 32'(commit_dst), 32'(k + 1));
         tick();
      end
      #5;
      chk("R4", "drained commit_valid", 32'(commit_valid), 32'd0);
      tick();

      // R9: reset with work in flight
      drive(1'b1, 3'd7, 8'h77, 1'b0, 2'd0, 1'b0);
      tick();
      drive(1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 1'b0);
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      #5;
      chk("R9", "mid-run alloc_idx", 32'(alloc_idx), 32'd0);
      chk("R9", "mid-run alloc_ready", 32'(alloc_ready), 32'd1);
      chk("R9", "mid-run commit_valid", 32'(commit_valid), 32'd0);
      tick();

      // R7: completion aimed at a free slot must not pre-mark it
      drive(1'b1, 3'd1, 8'h01, 1'b0, 2'd0, 1'b0);
      tick();
      drive(1'b0, 3'd0, 8'h00, 1'b1, 2'd1, 1'b0);
      tick();
      drive(1'b1, 3'd2, 8'h02, 1'b0, 2'd0, 1'b0);
      tick();
      drive(1'b0, 3'd0, 8'h00, 1'b1, 2'd0, 1'b0);
      tick();
      drive(1'b0, 3'd0, 8'h00, 1'b0, 2'd0, 1'b0);
      #5;
      chk("R4", "after free-slot test commit_valid", 32'(commit_valid), 32'd1);
      chk("R4", "after free-slot test commit_dst", 32'(commit_dst), 32'd1);
      tick();
      #5;
      chk("R7", "stale completion commit_valid", 32'(commit_valid), 32'd0);
      tick();

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule